// File: doc/BRIEF.md
# Parallel Segment Insertion Cell

This block is a reconfigurable cell for a scan network that carries test data on several lanes at once. Each lane has one shift cell. A single update cell, shared by all lanes, holds the select state. When select is low, each lane passes through its own shift cell and nothing else, so the cell acts as a one-bit bypass on every lane. When select is high, each lane's downstream test-data segment is spliced into the path just ahead of that lane's shift cell. The shift cell then takes its input from the segment's return, and the segment receives a shift enable.

The cell is opened or closed with one scan pass. The control value is shifted into the first lane's shift cell, and the update strobe copies it into the update cell. Only the first lane's shift cell feeds the update cell, so the other lanes' bits in that position carry no meaning for control. On capture, every shift cell loads the current select value, so the state can be read back on any lane. A register whose length does not divide evenly by the lane count is split into equal segments, with the last segment padded by extra shift cells. The padding lives in the segments, outside this cell.

Top module: `psib_parallel`

## Requirements
- R1: While `rst` is high at a clock edge, `seg_select` and every bit of `scan_out` become 0.
- R2: `seg_select` takes the value of the lane 0 shift cell (`scan_out[0]`) at an edge where `update_en` is high. It keeps its value at every other edge. The shift cells of lanes 1 and up never affect it.
- R3: With `seg_select` low, a shift edge (`shift_en` high, `capture_en` low) loads `scan_in[i]` into lane i's cell. `scan_out[i]` therefore follows `scan_in[i]` with one cycle of delay.
- R4: With `seg_select` high, a shift edge loads `seg_return[i]` into lane i's cell. `scan_in[i]` is not used for this.
- R5: `seg_shift_en[i]` equals `shift_en` AND `seg_select` for every lane, so a closed segment never shifts.
- R6: A capture edge (`capture_en` high) loads the current `seg_select` value into every shift cell. Capture takes priority over shift when both are high.
- R7: At an edge where `capture_en`, `shift_en` and `rst` are all low, every shift cell keeps its value.
- R8: When update and shift fall on the same edge, `seg_select` takes the lane 0 cell value from before that edge. The shift in that cycle is steered by the old select value.
- R9: `seg_scan_in[i]` carries `scan_in[i]` unchanged, so the segment sits between lane i's scan input and its shift cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test reset |
| capture_en | input | 1 | Capture-DR strobe |
| shift_en | input | 1 | Shift-DR strobe |
| update_en | input | 1 | Update-DR strobe |
| scan_in | input | LANES | Parallel scan input, one bit per lane |
| seg_return | input | LANES | Return from each lane's segment |
| scan_out | output | LANES | Parallel scan output, the lane shift cells |
| seg_scan_in | output | LANES | Scan data sent into each lane's segment |
| seg_shift_en | output | LANES | Shift enable for each lane's segment |
| seg_select | output | 1 | Shared select from the update cell |

## Verification
Two functions can act at one clock edge. The first is the update of the shared select cell from lane 0. The second is the shift that moves lane 0's cell. The bench drives update and shift high together with a known lane 0 bit and opposite data on the scan and return inputs. It then judges the result by two checks. The new select must equal the lane 0 bit from before the edge. The data each cell loaded must follow the old select value. Capture and shift are also driven together, and every cell must then hold the select value rather than the shifted data.

// File: rtl/psib_pkg.sv
package psib_pkg;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } cell_op_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } tap_strobe_t;

    // capture outranks shift; neither means hold
    function automatic cell_op_e pick_op(input tap_strobe_t s);
        if (s.capture)    return OP_CAPTURE;
        else if (s.shift) return OP_SHIFT;
        else              return OP_HOLD;
    endfunction

endpackage

// File: rtl/psib_update_cell.sv
module psib_update_cell (
    input  logic clk,
    input  logic rst,
    input  logic upd_i,
    input  logic d_i,
    output logic sel_o
);
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst)        sel_q <= 1'b0;
        else if (upd_i) sel_q <= d_i;
    end

    assign sel_o = sel_q;

    p_reset_closed_r1: assert property (@(posedge clk) rst |=> !sel_o);
    p_update_load_r2: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> (sel_o == $past(d_i)));
    p_update_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(sel_o));
endmodule

// File: rtl/psib_lane.sv
module psib_lane
    import psib_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  tap_strobe_t strobe_i,
    input  logic        sel_i,
    input  logic        scan_in_i,
    input  logic        seg_ret_i,
    output logic        cell_o,
    output logic        seg_tdi_o,
    output logic        seg_en_o
);
    cell_op_e op;
    logic     shift_src;
    logic     cell_q;

    assign op        = pick_op(strobe_i);
    assign shift_src = sel_i ? seg_ret_i : scan_in_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_q <= 1'b0;
        end else begin
            unique case (op)
                OP_CAPTURE: cell_q <= sel_i;
                OP_SHIFT:   cell_q <= shift_src;
                default:    cell_q <= cell_q;
            endcase
        end
    end

    assign cell_o    = cell_q;
    assign seg_tdi_o = scan_in_i;
    assign seg_en_o  = strobe_i.shift & sel_i;

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> !cell_o);
    p_bypass_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe_i.shift && !strobe_i.capture && !sel_i) |=> (cell_o == $past(scan_in_i)));
    p_open_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (strobe_i.shift && !strobe_i.capture && sel_i) |=> (cell_o == $past(seg_ret_i)));
    p_seg_gate_r5: assert property (@(posedge clk) disable iff (rst)
        seg_en_o |-> (sel_i && strobe_i.shift));
    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        strobe_i.capture |=> (cell_o == $past(sel_i)));
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!strobe_i.capture && !strobe_i.shift) |=> $stable(cell_o));
endmodule

// File: rtl/psib_parallel.sv
module psib_parallel
    import psib_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic [LANES-1:0] scan_in,
    input  logic [LANES-1:0] seg_return,
    output logic [LANES-1:0] scan_out,
    output logic [LANES-1:0] seg_scan_in,
    output logic [LANES-1:0] seg_shift_en,
    output logic             seg_select
);
    localparam int CTRL_LANE = 0;

    tap_strobe_t strobe;
    logic        sel;
    logic [LANES-1:0] cells;

    assign strobe = '{capture: capture_en, shift: shift_en, update: update_en};

    psib_update_cell u_upd (
        .clk   (clk),
        .rst   (rst),
        .upd_i (strobe.update),
        .d_i   (cells[CTRL_LANE]),
        .sel_o (sel)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        psib_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .strobe_i  (strobe),
            .sel_i     (sel),
            .scan_in_i (scan_in[i]),
            .seg_ret_i (seg_return[i]),
            .cell_o    (cells[i]),
            .seg_tdi_o (seg_scan_in[i]),
            .seg_en_o  (seg_shift_en[i])
        );
    end

    assign scan_out   = cells;
    assign seg_select = sel;

    // R8: a same-edge update sees the lane 0 cell from before the shift
    p_update_shift_r8: assert property (@(posedge clk) disable iff (rst)
        (update_en && shift_en) |=> (seg_select == $past(scan_out[CTRL_LANE])));
    // R5: all segment enables move together
    p_seg_uniform_r5: assert property (@(posedge clk) disable iff (rst)
        (seg_shift_en == '0) || (seg_shift_en == '1));
endmodule

// File: tb/psib_parallel_test.sv
module psib_parallel_test;
    localparam int  L      = 4;
    localparam time PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
    logic [L-1:0] scan_in = '0, seg_return = '0;
    logic [L-1:0] scan_out, seg_scan_in, seg_shift_en;
    logic         seg_select;

    always #(PERIOD/2) clk = ~clk;

    psib_parallel #(.LANES(L)) uut (
        .clk(clk), .rst(rst), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .scan_in(scan_in), .seg_return(seg_return),
        .scan_out(scan_out), .seg_scan_in(seg_scan_in),
        .seg_shift_en(seg_shift_en), .seg_select(seg_select)
    );

    typedef struct {
        logic [L-1:0] out;
        logic         sel;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_bad = 0;
    bit   done = 0;

    // independent model state
    logic         m_sel = 1'b0;
    logic [L-1:0] m_cell = '0;

    // monitor: compares registered outputs away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (scan_out !== e.out || seg_select !== e.sel) begin
                    n_bad++;
                    $display("FAIL %s: scan_out=%b sel=%b expected scan_out=%b sel=%b",
                             e.tag, scan_out, seg_select, e.out, e.sel);
                end
            end
        end
    end

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; capture_en = 0; shift_en = 0; update_en = 0;
        @(posedge clk);
        m_sel = 1'b0; m_cell = '0;
        q.push_back('{out: m_cell, sel: m_sel, tag: tag});
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input logic c, input logic s, input logic u,
                        input logic [L-1:0] si, input logic [L-1:0] sr,
                        input string tag);
        logic [L-1:0] exp_en;
        logic [L-1:0] n_cell;
        logic         n_sel;
        @(negedge clk);
        capture_en = c; shift_en = s; update_en = u;
        scan_in = si; seg_return = sr;
        #1;
        exp_en = s ? {L{m_sel}} : '0;
        n_chk++;
        if (seg_shift_en !== exp_en) begin
            n_bad++;
            $display("FAIL R5 %s: seg_shift_en=%b expected %b", tag, seg_shift_en, exp_en);
        end
        n_chk++;
        if (seg_scan_in !== si) begin
            n_bad++;
            $display("FAIL R9 %s: seg_scan_in=%b expected %b", tag, seg_scan_in, si);
        end
        @(posedge clk);
        n_sel  = u ? m_cell[0] : m_sel;
        n_cell = c ? {L{m_sel}} : (s ? (m_sel ? sr : si) : m_cell);
        m_sel  = n_sel;
        m_cell = n_cell;
        q.push_back('{out: m_cell, sel: m_sel, tag: tag});
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset state");
        // closed: 1-bit bypass per lane
        step(0, 1, 0, 4'b1010, 4'b0101, "R3 bypass a");
        step(0, 1, 0, 4'b0110, 4'b1111, "R3 bypass b");
        step(0, 1, 0, 4'b1111, 4'b0000, "R3 bypass c");
        step(0, 0, 0, 4'b0000, 4'b1111, "R7 hold closed");
        step(0, 0, 0, 4'b0101, 4'b1010, "R7 hold closed 2");
        step(1, 0, 0, 4'b1111, 4'b1111, "R6 capture closed");
        // lanes 1..3 high, lane 0 low: update must stay closed
        step(0, 1, 0, 4'b1110, 4'b0001, "R3 load control low");
        step(0, 0, 1, 4'b0000, 4'b0000, "R2 others ignored");
        // lane 0 high: update opens
        step(0, 1, 0, 4'b0001, 4'b1110, "R3 load control high");
        step(0, 0, 1, 4'b0000, 4'b0000, "R2 open");
        step(0, 0, 0, 4'b0000, 4'b0000, "R2 hold select");
        // open: cells take segment return
        step(0, 1, 0, 4'b0000, 4'b1011, "R4 open shift a");
        step(0, 1, 0, 4'b1111, 4'b0100, "R4 open shift b");
        step(0, 0, 0, 4'b1111, 4'b1111, "R7 hold open");
        step(1, 0, 0, 4'b0000, 4'b0000, "R6 capture open");
        step(1, 1, 0, 4'b0000, 4'b0000, "R6 capture over shift");
        // same-edge update and shift: lane 0 cell is 1, return drives 0
        step(0, 1, 1, 4'b1111, 4'b0000, "R8 update+shift keep open");
        step(0, 1, 1, 4'b1111, 4'b0101, "R8 update+shift close");
        step(0, 1, 0, 4'b1001, 4'b0110, "R8 closed after");
        step(0, 0, 1, 4'b0000, 4'b0000, "R2 reopen");
        do_reset("R1 reset mid-run");
        step(0, 1, 0, 4'b0011, 4'b1100, "R3 after reset");
        for (int k = 0; k < 300; k++) begin
            logic [2:0] st;
            st = 3'($urandom);
            step(st[2], st[1], st[0], 4'($urandom), 4'($urandom), "R2/R3/R4/R6 mix");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule